// File: doc/BRIEF.md
# Complement-Pair Toggle Test Controller

This block is a built-in test sequencer for a combinational network built only from three-input majority gates and inverters. A single start pulse launches a run of three steps. The network inputs receive a seed vector, then its bitwise complement, then the seed again. Each step lasts a programmable number of settle cycles, and the network response is captured in the last cycle of each step.

Every node of a majority/inverter network inverts when all of its inputs invert. The controller uses this to check the network without a reference: the response to the complemented seed must be the exact bitwise inverse of the response to the seed. The second application of the seed must repeat the first response. An optional expected response, latched at start, can also be compared with the first response. The seed, complement, seed order toggles every internal node both up and down.

Two global control lines feed gates that are meant to act as AND (constant 0) or OR (constant 1). In functional mode the lines sit at 0 and 1. In test mode they take the values in a two-bit override and are complemented together with the seed. This makes them true extra inputs, so the complement check also holds across those gates.

Top module: `cpt_test_ctrl`

## Requirements
- R1: After reset, busy, doneValid and all three fail flags are 0, netIn is all zeros, ctrlLo is 0 and ctrlHi is 1.
- R2: A start pulse seen while idle begins a run. netIn carries the seed for N cycles, then its bitwise complement for N cycles, then the seed for N cycles. N is the settleCycles value latched at start, and a value of 0 is treated as 1. The seed is latched at start.
- R3: doneValid is high for exactly one cycle, 3N cycles after the clock edge that accepted the start. busy is high during the three apply steps and low otherwise.
- R4: A start pulse that arrives while a run is in progress is ignored. The run keeps its seed, its settle count and its timing.
- R5: complFail is set when the response captured in the last cycle of the complement step differs in any bit from the bitwise inverse of the response captured in the last cycle of the first seed step.
- R6: repeatFail is set when the response captured in the last cycle of the second seed step differs in any bit from the first seed response.
- R7: goldenFail is set when goldenEn was 1 at start and the first seed response differs from goldenVec latched at start. With goldenEn 0 at start, goldenFail stays 0.
- R8: The fail flags are cleared by the edge that accepts a start, are final when doneValid is high, and hold their values after the run until the next accepted start.
- R9: With testMode 0, ctrlLo is 0 and ctrlHi is 1 in every step.
- R10: With testMode 1, ctrlLo equals ctrlOverride[0] and ctrlHi equals ctrlOverride[1], both inverted while the complement step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins a run when idle |
| seedVec | input | IN_W | Seed vector, latched at start |
| settleCycles | input | SETTLE_W | Cycles per step, latched at start (0 means 1) |
| goldenVec | input | OUT_W | Expected response to the seed, latched at start |
| goldenEn | input | 1 | Enables the expected-response compare, latched at start |
| testMode | input | 1 | Selects test values for the control lines |
| ctrlOverride | input | 2 | Test values: bit 0 for ctrlLo, bit 1 for ctrlHi |
| netOut | input | OUT_W | Response from the network under test |
| netIn | output | IN_W | Stimulus to the network under test |
| ctrlLo | output | 1 | Control line that is 0 in functional mode |
| ctrlHi | output | 1 | Control line that is 1 in functional mode |
| busy | output | 1 | A run is applying stimulus |
| doneValid | output | 1 | One-cycle strobe when the results are final |
| complFail | output | 1 | Complement response mismatch, sticky |
| repeatFail | output | 1 | Repeated seed response mismatch, sticky |
| goldenFail | output | 1 | Expected response mismatch, sticky |

## Verification
On every cycle, the assertions check the following. doneValid lasts one cycle and only follows the third capture. At most one capture strobe fires at a time. The step counter stays inside its bound. netIn turns into the exact inverse of itself on entry to the complement step, and so do the test-mode control lines. The fail flags never fall except after an accepted start. Only the bench scenarios can show the rest, by running a model network with injected faults: that each flag rises for the right mismatch and for nothing else, that the run timing matches 3N for several settle values including 0, that a start during a run changes nothing, and that the functional-mode constants break the complement check while test mode restores it.

// File: rtl/cpt_test_pkg.sv
package cpt_test_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_APPLY_V,
    S_APPLY_NV,
    S_APPLY_V2,
    S_DONE
  } seqState_t;

  typedef struct packed {
    logic startRun;
    logic applyInv;
    logic capV;
    logic capNv;
    logic capV2;
    logic done;
  } ctrlStrobe_t;

endpackage

// File: rtl/cpt_test_seq.sv
module cpt_test_seq
  import cpt_test_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                busy,
  output ctrlStrobe_t         strobe
);

  localparam logic [SETTLE_W-1:0] ONE = SETTLE_W'(1);

  seqState_t           state;
  logic [SETTLE_W-1:0] cnt;
  logic [SETTLE_W-1:0] settleReg;
  logic                lastCycle;
  logic                inApply;

  assign inApply   = (state == S_APPLY_V) || (state == S_APPLY_NV) || (state == S_APPLY_V2);
  assign lastCycle = (cnt == settleReg - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      settleReg <= ONE;
    end else begin
      case (state)
        S_IDLE: begin
          if (startPulse) begin
            state     <= S_APPLY_V;
            cnt       <= '0;
            settleReg <= (settleCycles == '0) ? ONE : settleCycles;
          end
        end
        S_APPLY_V, S_APPLY_NV, S_APPLY_V2: begin
          if (lastCycle) begin
            cnt <= '0;
            case (state)
              S_APPLY_V:  state <= S_APPLY_NV;
              S_APPLY_NV: state <= S_APPLY_V2;
              default:    state <= S_DONE;
            endcase
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.startRun = (state == S_IDLE) && startPulse;
    strobe.applyInv = (state == S_APPLY_NV);
    strobe.capV     = (state == S_APPLY_V)  && lastCycle;
    strobe.capNv    = (state == S_APPLY_NV) && lastCycle;
    strobe.capV2    = (state == S_APPLY_V2) && lastCycle;
    strobe.done     = (state == S_DONE);
  end

  assign busy = inApply;

  AST_CAPTURE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capV, strobe.capNv, strobe.capV2}));  // R2

  AST_STEP_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < settleReg));  // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> !strobe.done);  // R3

  AST_DONE_AFTER_LAST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capV2 |=> strobe.done);  // R3

  AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !lastCycle) |=> (busy && $stable(settleReg)));  // R4

endmodule

// File: rtl/cpt_test_datapath.sv
module cpt_test_datapath
  import cpt_test_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [IN_W-1:0]  seedVec,
  input  logic [OUT_W-1:0] goldenVec,
  input  logic             goldenEn,
  input  logic             testMode,
  input  logic [1:0]       ctrlOverride,
  input  logic [OUT_W-1:0] netOut,
  output logic [IN_W-1:0]  netIn,
  output logic             ctrlLo,
  output logic             ctrlHi,
  output logic             complFail,
  output logic             repeatFail,
  output logic             goldenFail
);

  logic [IN_W-1:0]  seedReg;
  logic [OUT_W-1:0] goldReg;
  logic             goldEnReg;
  logic [OUT_W-1:0] respV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedReg    <= '0;
      goldReg    <= '0;
      goldEnReg  <= 1'b0;
      respV      <= '0;
      complFail  <= 1'b0;
      repeatFail <= 1'b0;
      goldenFail <= 1'b0;
    end else begin
      if (strobe.startRun) begin
        seedReg    <= seedVec;
        goldReg    <= goldenVec;
        goldEnReg  <= goldenEn;
        complFail  <= 1'b0;
        repeatFail <= 1'b0;
        goldenFail <= 1'b0;
      end
      if (strobe.capV) begin
        respV <= netOut;
        if (goldEnReg && (netOut != goldReg)) goldenFail <= 1'b1;
      end
      if (strobe.capNv && (netOut != ~respV)) complFail  <= 1'b1;
      if (strobe.capV2 && (netOut != respV))  repeatFail <= 1'b1;
    end
  end

  assign netIn  = strobe.applyInv ? ~seedReg : seedReg;
  assign ctrlLo = testMode & (ctrlOverride[0] ^ strobe.applyInv);
  assign ctrlHi = ~testMode | (ctrlOverride[1] ^ strobe.applyInv);

  AST_INVERT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.applyInv) |-> (netIn == ~$past(netIn)));  // R2

  AST_TEST_LINES_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(strobe.applyInv) && testMode && $past(testMode) && $stable(ctrlOverride))
      |-> ((ctrlLo != $past(ctrlLo)) && (ctrlHi != $past(ctrlHi))));  // R10

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.startRun |=> (!$fell(complFail) && !$fell(repeatFail) && !$fell(goldenFail)));  // R8

  AST_GOLDEN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capV && !goldEnReg && !goldenFail) |=> !goldenFail);  // R7

endmodule

// File: rtl/cpt_test_ctrl.sv
module cpt_test_ctrl
  import cpt_test_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int OUT_W    = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [IN_W-1:0]     seedVec,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [OUT_W-1:0]    goldenVec,
  input  logic                goldenEn,
  input  logic                testMode,
  input  logic [1:0]          ctrlOverride,
  input  logic [OUT_W-1:0]    netOut,
  output logic [IN_W-1:0]     netIn,
  output logic                ctrlLo,
  output logic                ctrlHi,
  output logic                busy,
  output logic                doneValid,
  output logic                complFail,
  output logic                repeatFail,
  output logic                goldenFail
);

  ctrlStrobe_t strobe;

  cpt_test_seq #(.SETTLE_W(SETTLE_W)) u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .settleCycles (settleCycles),
    .busy         (busy),
    .strobe       (strobe)
  );

  cpt_test_datapath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .seedVec      (seedVec),
    .goldenVec    (goldenVec),
    .goldenEn     (goldenEn),
    .testMode     (testMode),
    .ctrlOverride (ctrlOverride),
    .netOut       (netOut),
    .netIn        (netIn),
    .ctrlLo       (ctrlLo),
    .ctrlHi       (ctrlHi),
    .complFail    (complFail),
    .repeatFail   (repeatFail),
    .goldenFail   (goldenFail)
  );

  assign doneValid = strobe.done;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy);  // R3

endmodule

// File: tb/cpt_test_ctrl_tb.sv
module cpt_test_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8;
  localparam int OUT_W = 4;
  localparam int SETTLE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [IN_W-1:0] seedVec = '0;
  logic [SETTLE_W-1:0] settleCycles = '0;
  logic [OUT_W-1:0] goldenVec = '0;
  logic goldenEn = 1'b0;
  logic testMode = 1'b0;
  logic [1:0] ctrlOverride = 2'b00;
  logic [OUT_W-1:0] netOut;
  logic [IN_W-1:0] netIn;
  logic ctrlLo, ctrlHi, busy, doneValid, complFail, repeatFail, goldenFail;

  logic stuckEn = 1'b0;
  logic flakyEn = 1'b0;
  logic flipClr = 1'b1;
  logic sawInv = 1'b0;
  logic [IN_W-1:0] curSeed = '0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpt_test_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .SETTLE_W(SETTLE_W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .seedVec(seedVec),
    .settleCycles(settleCycles), .goldenVec(goldenVec), .goldenEn(goldenEn),
    .testMode(testMode), .ctrlOverride(ctrlOverride), .netOut(netOut),
    .netIn(netIn), .ctrlLo(ctrlLo), .ctrlHi(ctrlHi), .busy(busy),
    .doneValid(doneValid), .complFail(complFail), .repeatFail(repeatFail),
    .goldenFail(goldenFail)
  );

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Model network: majority gates, inverters, one AND-type and one OR-type gate.
  function automatic logic [OUT_W-1:0] netModel(input logic [IN_W-1:0] i, input logic lo,
                                                input logic hi, input logic stuck, input logic flip);
    logic [OUT_W-1:0] o;
    o[0] = maj(i[0], i[1], i[2]);
    o[1] = stuck ? 1'b1 : maj(i[3], ~i[4], i[5]);
    o[2] = ~maj(i[6], i[7], lo);
    o[3] = maj(o[0], ~i[1], hi) ^ flip;
    return o;
  endfunction

  always @(posedge clk) begin
    if (flipClr) sawInv <= 1'b0;
    else if (netIn == ~curSeed) sawInv <= 1'b1;
  end

  assign netOut = netModel(netIn, ctrlLo, ctrlHi, stuckEn,
                           flakyEn && sawInv && (netIn == curSeed));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one sequence and checks timing, stimulus, control lines and flags.
  task automatic runSeq(input logic [IN_W-1:0] seed, input int settle, input logic tm,
                        input logic [1:0] ovr, input logic gEn, input logic gBad,
                        input logic stuck, input logic flaky, input logic midStart);
    int n;
    int cnt;
    logic loV, hiV, loN, hiN;
    logic [OUT_W-1:0] r1, rn, r2, gold;
    logic eCompl, eRep, eGold;
    n = (settle == 0) ? 1 : settle;
    loV = tm ? ovr[0] : 1'b0;
    hiV = tm ? ovr[1] : 1'b1;
    loN = tm ? ~ovr[0] : 1'b0;
    hiN = tm ? ~ovr[1] : 1'b1;
    r1 = netModel(seed, loV, hiV, stuck, 1'b0);
    rn = netModel(~seed, loN, hiN, stuck, 1'b0);
    r2 = netModel(seed, loV, hiV, stuck, flaky);
    gold = gBad ? (r1 ^ 4'b0100) : r1;
    eCompl = (rn != ~r1);
    eRep = (r2 != r1);
    eGold = gEn && (r1 != gold);

    @(negedge clk);
    flipClr = 1'b1;
    stuckEn = stuck;
    flakyEn = flaky;
    curSeed = seed;
    seedVec = seed;
    settleCycles = SETTLE_W'(settle);
    testMode = tm;
    ctrlOverride = ovr;
    goldenEn = gEn;
    goldenVec = gold;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    flipClr = 1'b0;
    chk(!complFail && !repeatFail && !goldenFail, "R8", "flags cleared at start",
        {complFail, repeatFail, goldenFail}, 0);
    chk(busy == 1'b1, "R3", "busy after start", busy, 1);
    chk(netIn == seed, "R2", "netIn first step", netIn, seed);
    chk(ctrlLo == loV && ctrlHi == hiV, tm ? "R10" : "R9", "ctrl lines seed step",
        {ctrlLo, ctrlHi}, {loV, hiV});
    cnt = 0;
    while (!doneValid && cnt < 2000) begin
      if (midStart && cnt == 1) begin
        seedVec = ~seed;
        settleCycles = SETTLE_W'(settle + 3);
        startPulse = 1'b1;
      end
      @(negedge clk);
      startPulse = 1'b0;
      cnt++;
      if (cnt == n) begin
        chk(netIn == ~seed, midStart ? "R4" : "R2", "netIn complement step", netIn, ~seed);
        chk(ctrlLo == loN && ctrlHi == hiN, tm ? "R10" : "R9", "ctrl lines complement step",
            {ctrlLo, ctrlHi}, {loN, hiN});
      end
      if (cnt == 2 * n) begin
        chk(netIn == seed, "R2", "netIn repeat step", netIn, seed);
        chk(busy == 1'b1, "R3", "busy in repeat step", busy, 1);
      end
    end
    chk(cnt == 3 * n, midStart ? "R4" : "R3", "doneValid cycle", cnt, 3 * n);
    chk(busy == 1'b0, "R3", "busy low at done", busy, 0);
    chk(complFail == eCompl, "R5", "complFail", complFail, eCompl);
    chk(repeatFail == eRep, "R6", "repeatFail", repeatFail, eRep);
    chk(goldenFail == eGold, "R7", "goldenFail", goldenFail, eGold);
    @(negedge clk);
    chk(doneValid == 1'b0, "R3", "doneValid one cycle", doneValid, 0);
    repeat (3) @(negedge clk);
    chk(complFail == eCompl && repeatFail == eRep && goldenFail == eGold, "R8",
        "flags held after run", {complFail, repeatFail, goldenFail}, {eCompl, eRep, eGold});
  endtask

  task automatic testReset();
    chk(!busy && !doneValid, "R1", "busy/done at reset", {busy, doneValid}, 0);
    chk(!complFail && !repeatFail && !goldenFail, "R1", "flags at reset",
        {complFail, repeatFail, goldenFail}, 0);
    chk(netIn == '0, "R1", "netIn at reset", netIn, 0);
    chk(!ctrlLo && ctrlHi, "R1", "ctrl lines at reset", {ctrlLo, ctrlHi}, 2'b01);
  endtask

  task automatic testCleanRuns();
    runSeq(8'hA5, 2, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R5 R7 pass case
    runSeq(8'h3C, 4, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runSeq(8'h00, 0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // settle 0 acts as 1, R2
  endtask

  task automatic testFaults();
    runSeq(8'h5A, 3, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // stuck node, R5
    runSeq(8'h96, 2, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // flaky node, R6
    runSeq(8'h71, 1, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // golden mismatch, R7
    runSeq(8'h71, 1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // golden disabled, R7
  endtask

  task automatic testControlLines();
    runSeq(8'h40, 2, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // functional constants, R9
    runSeq(8'h40, 2, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // test mode, R10
  endtask

  task automatic testBusyStart();
    runSeq(8'hC3, 3, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // R4
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCleanRuns();
    testFaults();
    testControlLines();
    testBusyStart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule